// File: doc/BRIEF.md
# Core Low-Power Mode Controller

This controller moves a processor core between normal operation and four low-power states of increasing depth. In the lightest state only the functional-unit clocks stop and the cache keeps running so it stays coherent. The next state also stops the cache. The third stops the main core clock. The deepest also switches the PLL off. The controller drives one enable per clock domain. The gating cells and the PLL itself are outside the block.

Software asks for a state through a request handshake that is only open while the core runs normally. The wake source depends on the depth. Every state wakes on an external interrupt, and the cache-off state can also wake on a programmable timeout counted in an always-on domain. After a wake event the core stays stalled for a latency that grows with depth. During that time every clock is already re-enabled, and `core_ready` rises only when the latency has elapsed.

Top module: `core_sleep_ctrl`

## Requirements
- R1: While reset is asserted and right after it, the state is run (`mode_o` = 0): `waking` = 0, `core_ready` = 1, `req_ready` = 1, and all four clock enables are 1.
- R2: `req_ready` is 1 only in run and not waking. A handshake (`req_valid` and `req_ready` high at a clock edge) with `req_mode` 1 (doze), 2 (nap), 3 (sleep) or 4 (deep sleep with PLL off) enters that mode after that edge, and `core_ready` goes to 0. A handshake with code 0, 5, 6 or 7 leaves the block in run with all outputs unchanged.
- R3: In doze (not waking), `fu_clk_en` = 0, `cache_clk_en` = 1, `core_clk_en` = 1 and `pll_en` = 1.
- R4: In nap (not waking), `fu_clk_en` = 0, `cache_clk_en` = 0, `core_clk_en` = 1 and `pll_en` = 1.
- R5: In sleep (not waking), `fu_clk_en`, `cache_clk_en` and `core_clk_en` are 0 and `pll_en` is 1. In deep sleep, all four enables are 0.
- R6: A high `ext_irq` sampled at an edge wakes every low-power mode. A timeout wakes nap only. Doze, sleep and deep sleep ignore the timeout, whatever the value of `nap_limit`.
- R7: The nap timer restarts at the request edge that enters nap. Its wake event falls on the edge that comes `nap_limit` edges after entry. `nap_limit` = 0 disables the timeout. `nap_limit` is held stable while in nap.
- R8: `core_ready` rises exactly L edges after the edge that samples the wake event, and `mode_o` then returns to 0. L is 1 for doze, NAP_LAT for nap, SLEEP_LAT (default 10) for sleep and DEEP_LAT for deep sleep, with DEEP_LAT standing for a PLL relock time of about 100 us.
- R9: While waking, `waking` = 1, `mode_o` holds the mode being left, all four enables are 1, `core_ready` = 0 and `req_ready` = 0. Interrupts and timeouts have no further effect.
- R10: `ext_irq` while in run has no effect.
- R11: An interrupt and a nap timeout at the same edge cause one wake, with the nap latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Mode request is present |
| req_ready | output | 1 | Request can be accepted (run, not waking) |
| req_mode | input | 3 | Requested mode code (1 to 4 are valid) |
| nap_limit | input | TMR_W | Nap timeout in cycles, 0 disables it |
| ext_irq | input | 1 | External interrupt wake request |
| mode_o | output | 3 | Current mode code |
| waking | output | 1 | Wake latency in progress |
| core_ready | output | 1 | Core may execute |
| fu_clk_en | output | 1 | Functional-unit clock enable |
| cache_clk_en | output | 1 | Cache clock enable |
| core_clk_en | output | 1 | Main core clock enable |
| pll_en | output | 1 | PLL enable |

## Verification
In nap, the external interrupt and the timeout can reach the controller at the same edge. The bench sweeps the interrupt edge across the points just before, exactly on and after the timeout edge for several limits, and that includes raising the interrupt so that it is sampled on edge `nap_limit` itself. The coincident case is judged as correct when there is a single wake window of exactly NAP_LAT cycles, computed in the bench as the earlier of the two event edges plus the latency, with the per-cycle enables, `waking` and `core_ready` compared against that window.

// File: rtl/slp_pkg.sv
package slp_pkg;

  typedef enum logic [2:0] {
    MD_RUN   = 3'd0,
    MD_DOZE  = 3'd1,
    MD_NAP   = 3'd2,
    MD_SLEEP = 3'd3,
    MD_DEEP  = 3'd4
  } pmode_e;

  typedef struct packed {
    logic pll;
    logic core;
    logic cache;
    logic fu;
  } clk_en_t;

  function automatic logic code_ok(input logic [2:0] c);
    return (c >= 3'd1) && (c <= 3'd4);
  endfunction

endpackage

// File: rtl/slp_nap_timer.sv
module slp_nap_timer #(
  parameter int TW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          count_en,
  input  logic [TW-1:0] limit,
  output logic          expire
);

  logic [TW-1:0] tmr_q;

  assign expire = count_en && (limit != '0) && (tmr_q == limit - TW'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tmr_q <= '0;
    end else if (clear) begin
      tmr_q <= '0;
    end else if (count_en && !expire) begin
      tmr_q <= tmr_q + TW'(1);
    end
  end

  // R7: with a stable limit, the count never runs past the terminal value
  assert_tmr_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (count_en && limit != '0 && $stable(limit)) |-> (tmr_q < limit));

endmodule

// File: rtl/slp_wake_count.sv
module slp_wake_count #(
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  input  logic          tick,
  output logic          last
);

  logic [CW-1:0] cnt_q;

  assign last = tick && (cnt_q == CW'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= load_val;
    end else if (tick && cnt_q != '0) begin
      cnt_q <= cnt_q - CW'(1);
    end
  end

  // R8: a wake window never loads a zero latency
  assert_lat_nonzero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> (load_val != '0));

  // R8: while waking the counter is live (no underflow)
  assert_cnt_live_R8: assert property (@(posedge clk) disable iff (!rst_n)
    tick |-> (cnt_q != '0));

endmodule

// File: rtl/slp_clk_gate_ctrl.sv
module slp_clk_gate_ctrl
  import slp_pkg::*;
(
  input  pmode_e  mode,
  input  logic    waking,
  output clk_en_t en
);

  always_comb begin
    en = '{pll: 1'b1, core: 1'b1, cache: 1'b1, fu: 1'b1};
    if (!waking) begin
      unique case (mode)
        MD_DOZE:  en = '{pll: 1'b1, core: 1'b1, cache: 1'b1, fu: 1'b0};
        MD_NAP:   en = '{pll: 1'b1, core: 1'b1, cache: 1'b0, fu: 1'b0};
        MD_SLEEP: en = '{pll: 1'b1, core: 1'b0, cache: 1'b0, fu: 1'b0};
        MD_DEEP:  en = '{pll: 1'b0, core: 1'b0, cache: 1'b0, fu: 1'b0};
        default:  en = '{pll: 1'b1, core: 1'b1, cache: 1'b1, fu: 1'b1};
      endcase
    end
  end

endmodule

// File: rtl/core_sleep_ctrl.sv
module core_sleep_ctrl
  import slp_pkg::*;
#(
  parameter int TMR_W     = 8,
  parameter int NAP_LAT   = 4,
  parameter int SLEEP_LAT = 10,
  parameter int DEEP_LAT  = 20000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [2:0]       req_mode,
  input  logic [TMR_W-1:0] nap_limit,
  input  logic             ext_irq,
  output logic [2:0]       mode_o,
  output logic             waking,
  output logic             core_ready,
  output logic             fu_clk_en,
  output logic             cache_clk_en,
  output logic             core_clk_en,
  output logic             pll_en
);

  localparam int MAX_A   = (NAP_LAT > SLEEP_LAT) ? NAP_LAT : SLEEP_LAT;
  localparam int MAX_LAT = (DEEP_LAT > MAX_A) ? DEEP_LAT : MAX_A;
  localparam int CW      = $clog2(MAX_LAT + 1);

  localparam logic [CW-1:0] LAT_DOZE  = CW'(1);
  localparam logic [CW-1:0] LAT_NAP   = CW'(NAP_LAT);
  localparam logic [CW-1:0] LAT_SLEEP = CW'(SLEEP_LAT);
  localparam logic [CW-1:0] LAT_DEEP  = CW'(DEEP_LAT);

  pmode_e        mode_q;
  logic          wake_q;
  logic          accept;
  logic          take;
  logic          asleep;
  logic          irq_wake;
  logic          tmo;
  logic          wake_evt;
  logic          lat_last;
  logic [CW-1:0] lat_sel;
  clk_en_t       en;

  assign req_ready = (mode_q == MD_RUN) && !wake_q;
  assign accept    = req_valid && req_ready;
  assign take      = accept && code_ok(req_mode);
  assign asleep    = (mode_q != MD_RUN) && !wake_q;
  assign irq_wake  = asleep && ext_irq;
  assign wake_evt  = irq_wake || tmo;

  always_comb begin
    unique case (mode_q)
      MD_DOZE:  lat_sel = LAT_DOZE;
      MD_NAP:   lat_sel = LAT_NAP;
      MD_SLEEP: lat_sel = LAT_SLEEP;
      MD_DEEP:  lat_sel = LAT_DEEP;
      default:  lat_sel = LAT_DOZE;
    endcase
  end

  slp_nap_timer #(.TW(TMR_W)) u_tmr (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (take),
    .count_en (asleep && mode_q == MD_NAP),
    .limit    (nap_limit),
    .expire   (tmo)
  );

  slp_wake_count #(.CW(CW)) u_lat (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (wake_evt),
    .load_val (lat_sel),
    .tick     (wake_q),
    .last     (lat_last)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= MD_RUN;
      wake_q <= 1'b0;
    end else if (take) begin
      mode_q <= pmode_e'(req_mode);
    end else if (wake_evt) begin
      wake_q <= 1'b1;
    end else if (lat_last) begin
      wake_q <= 1'b0;
      mode_q <= MD_RUN;
    end
  end

  slp_clk_gate_ctrl u_gate (
    .mode   (mode_q),
    .waking (wake_q),
    .en     (en)
  );

  assign mode_o       = mode_q;
  assign waking       = wake_q;
  assign core_ready   = (mode_q == MD_RUN);
  assign fu_clk_en    = en.fu;
  assign cache_clk_en = en.cache;
  assign core_clk_en  = en.core;
  assign pll_en       = en.pll;

  // R2: run persists unless a valid code is handed over
  assert_run_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (core_ready && !(req_valid && code_ok(req_mode))) |=> core_ready);

  // R2: an accepted valid code becomes the mode on the next cycle
  assert_enter_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && code_ok(req_mode)) |=>
      (mode_o == $past(req_mode) && !waking && !core_ready));

  // R6: sleep and deep sleep leave only on an interrupt
  assert_irq_only_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ((mode_o == 3'd3 || mode_o == 3'd4) && !waking && !ext_irq) |=>
      ($stable(mode_o) && !waking));

  // R8: doze resumes one cycle after the interrupt edge
  assert_doze_lat_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o == 3'd1 && !waking && ext_irq) |=> (waking ##1 core_ready));

  // R9: during the wake window every clock runs and nothing is accepted
  assert_wake_clocks_R9: assert property (@(posedge clk) disable iff (!rst_n)
    waking |-> (fu_clk_en && cache_clk_en && core_clk_en && pll_en &&
                !core_ready && !req_ready));

  // R9: the reported mode does not change while waking, except back to run
  assert_wake_mode_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (waking && !lat_last) |=> (waking && $stable(mode_o)));

  // R5: the PLL is off only in deep sleep
  assert_pll_off_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !pll_en |-> (mode_o == 3'd4 && !waking));

endmodule

// File: tb/sim_core_sleep_ctrl.sv
`timescale 1ns/1ps
module sim_core_sleep_ctrl;

  localparam int TW = 4, NL = 3, SL = 10, DL = 40, BIG = 100000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic [2:0] req_mode = '0;
  logic [TW-1:0] nap_limit = '0;
  logic ext_irq = 1'b0;
  logic req_ready, waking, core_ready, fu_clk_en, cache_clk_en, core_clk_en, pll_en;
  logic [2:0] mode_o;

  int vecs = 0;
  int errs = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  core_sleep_ctrl #(.TMR_W(TW), .NAP_LAT(NL), .SLEEP_LAT(SL), .DEEP_LAT(DL)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_mode(req_mode), .nap_limit(nap_limit), .ext_irq(ext_irq),
    .mode_o(mode_o), .waking(waking), .core_ready(core_ready),
    .fu_clk_en(fu_clk_en), .cache_clk_en(cache_clk_en),
    .core_clk_en(core_clk_en), .pll_en(pll_en)
  );

  function automatic logic [9:0] obs();
    return {mode_o, waking, core_ready, req_ready, fu_clk_en, cache_clk_en, core_clk_en, pll_en};
  endfunction

  // phase 0 asleep, 1 waking, 2 run
  function automatic logic [9:0] expv(input int m, input int ph);
    logic [2:0] mc = 3'(m);
    if (ph == 2) return 10'b000_0_1_1_1111;
    if (ph == 1) return {mc, 3'b100, 4'b1111};
    return {mc, 3'b000, 1'b0, (m == 1), (m <= 2), (m != 4)};
  endfunction

  function automatic int lat_of(input int m);
    case (m)
      1: return 1;
      2: return NL;
      3: return SL;
      default: return DL;
    endcase
  endfunction

  task automatic chk(input string rq, input logic [9:0] act, input logic [9:0] exp);
    vecs++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%b expected=%b", rq, act, exp);
    end
  endtask

  // enter mode m; irq raised after edge d (sampled at edge d+1), d<0 means none
  task automatic run_case(input int m, input int d, input int lim, input string tag);
    int irq_e, tmo_e, w, l, ph;
    string ptag;
    irq_e = (d >= 0) ? d + 1 : BIG;
    tmo_e = (m == 2 && lim != 0) ? lim : BIG;
    w = (irq_e < tmo_e) ? irq_e : tmo_e;
    l = lat_of(m);
    @(negedge clk);
    nap_limit = TW'(lim);
    req_valid = 1'b1;
    req_mode  = 3'(m);
    @(posedge clk);
    for (int k = 0; k <= w + l + 1; k++) begin
      @(negedge clk);
      if (k == 0) req_valid = 1'b0;
      ph = (k < w) ? 0 : ((k < w + l) ? 1 : 2);
      if (ph == 0) ptag = (m == 1) ? "R3" : ((m == 2) ? "R4" : "R5");
      else if (ph == 1) ptag = "R9";
      else ptag = "R8";
      if (k == 0) ptag = {ptag, " R2"};
      chk($sformatf("%s %s mode=%0d irq=%0d lim=%0d cyc=%0d", tag, ptag, m, d, lim, k),
          obs(), expv(m, ph));
      ext_irq = (k == d);
    end
    ext_irq = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 in reset", obs(), expv(0, 2));
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 after reset", obs(), expv(0, 2));

    // R2: invalid codes are ignored
    for (int c = 0; c < 8; c++) begin
      if (c >= 1 && c <= 4) continue;
      @(negedge clk);
      req_valid = 1'b1;
      req_mode  = 3'(c);
      @(negedge clk);
      req_valid = 1'b0;
      chk($sformatf("R2 bad code %0d", c), obs(), expv(0, 2));
    end

    // R10: interrupt in run has no effect
    @(negedge clk);
    ext_irq = 1'b1;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk("R10 irq in run", obs(), expv(0, 2));
    end
    ext_irq = 1'b0;

    // every mode, interrupt at several distances, timeout disabled
    for (int m = 1; m <= 4; m++)
      for (int d = 0; d <= 4; d++)
        run_case(m, d, 0, "R6 R8");

    // R7: nap with timer disabled stays asleep until a late interrupt
    run_case(2, 25, 0, "R7 disabled");

    // nap timeout against interrupt, before, on and after the timeout edge
    for (int lim = 1; lim <= 6; lim++) begin
      if (lim >= 2) run_case(2, lim - 2, lim, "R6 irq first");
      run_case(2, lim - 1, lim, "R11 same edge");
      run_case(2, lim, lim, "R7 timeout first");
      run_case(2, -1, lim, "R7 timeout only");
    end

    // R6: a timeout value does not wake the other modes
    run_case(1, 6, 1, "R6 doze no tmo");
    run_case(3, 8, 2, "R6 sleep no tmo");
    run_case(4, 5, 3, "R6 deep no tmo");

    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errs++;
      vecs++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  == %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
    end
  end

endmodule